// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block walks a byte-addressed 64 KB memory on its own, either copying bytes from a source region to a destination region or scanning a source region for a given byte value. A client loads a source pointer, a destination pointer, a 16-bit byte counter, an 8-bit comparand and a 2-bit opcode, then pulses start. The opcode chooses copy or search, and single-step or repeat. The engine then runs memory reads and writes through a plain strobe interface that a wait input can stretch.

When it finishes, the block pulses done. It presents the updated pointers and counter, and three condition flags: counter-not-zero, last-compare-matched and search-mode. The state it leaves is exactly what a repeated string instruction would leave. A counter loaded as zero means 65536 iterations. Pointers wrap modulo 65536.

Top module: `blkmove_engine`

## Requirements
- R1: A copy step reads the byte at the source pointer, writes it to the destination pointer, and then both pointers advance by one.
- R2: Every step, copy or search, lowers the byte counter by one, modulo 65536.
- R3: Opcode bit 0 selects repeat (1) or single step (0). In single-step mode exactly one step runs. In repeat copy mode, steps run until the counter reaches zero. When an operation ends, done is high for exactly one cycle.
- R4: Opcode bit 1 selects search (1) or copy (0). A search step compares the byte at the source pointer with the comparand, advances the source pointer by one and never writes memory. The destination pointer is left unchanged.
- R5: A repeat search ends after the first compare that matches, or after the step that brings the counter to zero, whichever comes first.
- R6: While mem_wait is high during a read or write, the access is held: the strobe, the address and the write data stay constant, and nothing advances.
- R7: A counter loaded as zero runs 65536 steps, and pointers wrap from 0xFFFF to 0x0000.
- R8: At the end of an operation, flag_pv is 1 exactly when the counter is non-zero. flag_z is 1 when the last search compare matched and 0 after a copy. flag_n is 1 after a search and 0 after a copy.
- R9: A start pulse while busy is high is ignored. Busy stays high from the cycle after an accepted start through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation using the load values |
| op | input | 2 | bit 1: search/copy, bit 0: repeat/single |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte counter (0 means 65536) |
| cmp_in | input | 8 | Comparand for search |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle end-of-operation pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current byte counter |
| flag_z | output | 1 | Last search compare matched |
| flag_pv | output | 1 | Counter non-zero |
| flag_n | output | 1 | Last operation was a search |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle a read completes |
| mem_wait | input | 1 | Stretch the current access while high |

## Verification
The assertions take for granted that the memory returns read data in the same cycle that a read strobe meets a low mem_wait. They also assume that mem_wait is held only while an access is pending, so an access ends in the first cycle it sees wait low. The bench memory model answers combinationally. It changes mem_wait only just after a clock edge, from a repeating pattern, and it never raises start except in the deliberate busy-start test, so every access eventually completes. The 65536-step run uses search without wait states, which keeps it well inside the cycle budget.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
   typedef enum logic [1:0] {
      BM_IDLE  = 2'd0,
      BM_READ  = 2'd1,
      BM_WRITE = 2'd2,
      BM_FIN   = 2'd3
   } bm_state_e;

   localparam int unsigned OP_REPEAT_BIT = 0;
   localparam int unsigned OP_SEARCH_BIT = 1;
endpackage

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
   import blkmove_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic [1:0] op,
   input  logic mem_wait,
   input  logic match,
   input  logic last,
   output logic load,
   output logic step,
   output logic rd_ok,
   output logic mode_search,
   output logic mem_rd,
   output logic mem_wr,
   output logic busy,
   output logic done
);
   bm_state_e state_q, state_d;
   logic      search_q, repeat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= BM_IDLE;
         search_q <= 1'b0;
         repeat_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load) begin
            search_q <= op[OP_SEARCH_BIT];
            repeat_q <= op[OP_REPEAT_BIT];
         end
      end
   end

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      step    = 1'b0;
      rd_ok   = 1'b0;
      unique case (state_q)
         BM_IDLE: if (start) begin
            load    = 1'b1;
            state_d = BM_READ;
         end
         BM_READ: if (!mem_wait) begin
            rd_ok = 1'b1;
            if (search_q) begin
               step    = 1'b1;
               state_d = (repeat_q && !last && !match) ? BM_READ : BM_FIN;
            end else begin
               state_d = BM_WRITE;
            end
         end
         BM_WRITE: if (!mem_wait) begin
            step    = 1'b1;
            state_d = (repeat_q && !last) ? BM_READ : BM_FIN;
         end
         BM_FIN: state_d = BM_IDLE;
         default: state_d = BM_IDLE;
      endcase
   end

   assign mem_rd      = (state_q == BM_READ);
   assign mem_wr      = (state_q == BM_WRITE);
   assign busy        = (state_q != BM_IDLE);
   assign done        = (state_q == BM_FIN);
   assign mode_search = search_q;

   assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_search_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> !search_q);
endmodule

// File: rtl/blkmove_dp.sv
module blkmove_dp #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          rd_ok,
   input  logic          mode_search,
   input  logic          mem_wr,
   input  logic [AW-1:0] src_in,
   input  logic [AW-1:0] dst_in,
   input  logic [CW-1:0] cnt_in,
   input  logic [DW-1:0] cmp_in,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] src_q,
   output logic [AW-1:0] dst_q,
   output logic [CW-1:0] cnt_q,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          match,
   output logic          last,
   output logic          flag_z,
   output logic          flag_pv,
   output logic          flag_n
);
   localparam logic [AW-1:0] PTR_ONE = AW'(1);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   logic [DW-1:0] cmp_q, byte_q;
   logic [CW-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q - CNT_ONE;
   assign last    = (cnt_nxt == '0);
   assign match   = (mem_rdata == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         cmp_q   <= '0;
         byte_q  <= '0;
         flag_z  <= 1'b0;
         flag_pv <= 1'b0;
         flag_n  <= 1'b0;
      end else if (load) begin
         src_q <= src_in;
         dst_q <= dst_in;
         cnt_q <= cnt_in;
         cmp_q <= cmp_in;
      end else begin
         if (rd_ok && !mode_search) byte_q <= mem_rdata;
         if (step) begin
            src_q   <= src_q + PTR_ONE;
            cnt_q   <= cnt_nxt;
            flag_pv <= !last;
            flag_n  <= mode_search;
            flag_z  <= mode_search && match;
            if (!mode_search) dst_q <= dst_q + PTR_ONE;
         end
      end
   end

   assign mem_addr  = mem_wr ? dst_q : src_q;
   assign mem_wdata = byte_q;

   assert_pv_tracks_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(step) |-> (flag_pv == (cnt_q != '0)));
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op,
   input  logic [AW-1:0] src_in,
   input  logic [AW-1:0] dst_in,
   input  logic [CW-1:0] cnt_in,
   input  logic [DW-1:0] cmp_in,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] src_out,
   output logic [AW-1:0] dst_out,
   output logic [CW-1:0] cnt_out,
   output logic          flag_z,
   output logic          flag_pv,
   output logic          flag_n,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_wait
);
   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("blkmove_engine: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("blkmove_engine: DW must be positive");
      end
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("blkmove_engine: CW out of range");
      end
   endgenerate

   logic load, step, rd_ok, mode_search, match, last;

   blkmove_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .op          (op),
      .mem_wait    (mem_wait),
      .match       (match),
      .last        (last),
      .load        (load),
      .step        (step),
      .rd_ok       (rd_ok),
      .mode_search (mode_search),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .busy        (busy),
      .done        (done)
   );

   blkmove_dp #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .step        (step),
      .rd_ok       (rd_ok),
      .mode_search (mode_search),
      .mem_wr      (mem_wr),
      .src_in      (src_in),
      .dst_in      (dst_in),
      .cnt_in      (cnt_in),
      .cmp_in      (cmp_in),
      .mem_rdata   (mem_rdata),
      .src_q       (src_out),
      .dst_q       (dst_out),
      .cnt_q       (cnt_out),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .match       (match),
      .last        (last),
      .flag_z      (flag_z),
      .flag_pv     (flag_pv),
      .flag_n      (flag_n)
   );

   assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && mem_wait) |=>
         ($stable(mem_rd) && $stable(mem_wr) && $stable(mem_addr) && $stable(mem_wdata)));
   assert_ptr_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (src_out == AW'($past(src_out) + 1'b1)));
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt_out == CW'($past(cnt_out) - 1'b1)));
   assert_search_dst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mode_search) |=> $stable(dst_out));
endmodule

// File: tb/test_blkmove_engine.sv
module test_blkmove_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
   logic [7:0]  cmp_in = '0;
   logic        busy, done, flag_z, flag_pv, flag_n, mem_rd, mem_wr;
   logic [15:0] src_out, dst_out, cnt_out, mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_wait = 1'b0;
   logic        wait_en = 1'b0;
   int unsigned wait_ctr = 0;
   int          total = 0, bad = 0;
   int          cycles;
   logic [7:0]  mem [0:1023];

   always #2 clk = ~clk;

   blkmove_engine i_blkmove_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .cmp_in(cmp_in),
      .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
      .cnt_out(cnt_out), .flag_z(flag_z), .flag_pv(flag_pv), .flag_n(flag_n),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait)
   );

   assign mem_rdata = mem[mem_addr[9:0]];

   always @(posedge clk) begin
      if (mem_wr && !mem_wait) mem[mem_addr[9:0]] <= mem_wdata;
   end

   initial begin
      forever begin
         @(posedge clk);
         #1;
         wait_ctr = wait_ctr + 1;
         mem_wait = wait_en && ((wait_ctr % 3) != 0);
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
   endtask

   task automatic launch(input logic [1:0] o, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] c, input logic [7:0] k);
      @(negedge clk);
      op = o; src_in = s; dst_in = d; cnt_in = c; cmp_in = k; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      cycles = 1;
      while (!done && cycles < 150000) begin
         @(negedge clk);
         cycles++;
      end
      if (!done) chk("R3", "watchdog", 0, 1);
   endtask

   task automatic t_reset();
      chk("R9", "busy after reset", busy, 0);
      chk("R3", "done after reset", done, 0);
      chk("R6", "strobes after reset", {mem_rd, mem_wr}, 0);
      chk("R8", "flags after reset", {flag_z, flag_pv, flag_n}, 0);
   endtask

   task automatic t_single_copy();
      clear_mem();
      mem[10'h010] = 8'hA5;
      launch(2'b00, 16'h0010, 16'h0100, 16'd5, 8'h00);
      wait_done();
      @(negedge clk);
      chk("R1", "copied byte", mem[10'h100], 8'hA5);
      chk("R3", "single copy wrote only one", mem[10'h101], 8'h00);
      chk("R1", "src after single", src_out, 16'h0011);
      chk("R1", "dst after single", dst_out, 16'h0101);
      chk("R2", "cnt after single", cnt_out, 16'd4);
      chk("R8", "flags single copy", {flag_z, flag_pv, flag_n}, 3'b010);
      chk("R3", "done lasts one cycle", done, 0);
   endtask

   task automatic t_repeat_copy_wait();
      int errs;
      clear_mem();
      for (int i = 0; i < 8; i++) mem[10'h020 + i] = 8'(i * 7 + 3);
      wait_en = 1'b1;
      launch(2'b01, 16'h0020, 16'h0200, 16'd8, 8'h00);
      wait_done();
      wait_en = 1'b0;
      errs = 0;
      for (int i = 0; i < 8; i++) if (mem[10'h200 + i] != 8'(i * 7 + 3)) errs++;
      chk("R6", "copy with waits intact", errs, 0);
      chk("R3", "repeat copy stops at zero", mem[10'h208], 8'h00);
      chk("R3", "cnt at end", cnt_out, 0);
      chk("R1", "src at end", src_out, 16'h0028);
      chk("R1", "dst at end", dst_out, 16'h0208);
      chk("R8", "flags repeat copy", {flag_z, flag_pv, flag_n}, 3'b000);
   endtask

   task automatic t_search_match();
      clear_mem();
      for (int i = 0; i < 16; i++) mem[10'h040 + i] = 8'(i);
      mem[10'h045] = 8'h5A;
      mem[10'h04A] = 8'h5A;
      wait_en = 1'b1;
      launch(2'b11, 16'h0040, 16'h0300, 16'd16, 8'h5A);
      wait_done();
      wait_en = 1'b0;
      chk("R5", "search stops after first match src", src_out, 16'h0046);
      chk("R5", "search cnt", cnt_out, 16'd10);
      chk("R4", "search dst unchanged", dst_out, 16'h0300);
      chk("R8", "flags search match", {flag_z, flag_pv, flag_n}, 3'b111);
      chk("R4", "search wrote nothing", mem[10'h300], 8'h00);
   endtask

   task automatic t_search_nomatch();
      clear_mem();
      for (int i = 0; i < 4; i++) mem[10'h060 + i] = 8'h11 + 8'(i);
      launch(2'b11, 16'h0060, 16'h0000, 16'd4, 8'hEE);
      wait_done();
      chk("R5", "no match src", src_out, 16'h0064);
      chk("R5", "no match cnt", cnt_out, 0);
      chk("R8", "flags no match", {flag_z, flag_pv, flag_n}, 3'b001);
   endtask

   task automatic t_search_last_match();
      clear_mem();
      mem[10'h070] = 8'h01; mem[10'h071] = 8'h02; mem[10'h072] = 8'h33;
      launch(2'b11, 16'h0070, 16'h0000, 16'd3, 8'h33);
      wait_done();
      chk("R5", "match on final step src", src_out, 16'h0073);
      chk("R8", "flags match at zero", {flag_z, flag_pv, flag_n}, 3'b101);
   endtask

   task automatic t_single_search();
      clear_mem();
      mem[10'h090] = 8'h44;
      launch(2'b10, 16'h0090, 16'h0123, 16'd9, 8'h55);
      wait_done();
      chk("R3", "single search src", src_out, 16'h0091);
      chk("R2", "single search cnt", cnt_out, 16'd8);
      chk("R8", "flags single search", {flag_z, flag_pv, flag_n}, 3'b011);
   endtask

   task automatic t_wrap_copy();
      clear_mem();
      mem[10'h3FE] = 8'hC1; mem[10'h3FF] = 8'hC2; mem[10'h000] = 8'hC3; mem[10'h001] = 8'hC4;
      launch(2'b01, 16'hFFFE, 16'h0300, 16'd4, 8'h00);
      wait_done();
      chk("R7", "src wraps", src_out, 16'h0002);
      chk("R7", "byte after wrap copied", mem[10'h302], 8'hC3);
      chk("R7", "last byte copied", mem[10'h303], 8'hC4);
   endtask

   task automatic t_zero_count();
      clear_mem();
      launch(2'b11, 16'h0080, 16'h0000, 16'd0, 8'hEE);
      wait_done();
      chk("R7", "65536 steps bring src back", src_out, 16'h0080);
      chk("R7", "count ends at zero", cnt_out, 0);
      chk("R7", "ran at least 65536 cycles", int'(cycles >= 65536), 1);
      chk("R8", "flags zero count", {flag_z, flag_pv, flag_n}, 3'b001);
   endtask

   task automatic t_start_busy();
      clear_mem();
      for (int i = 0; i < 6; i++) mem[10'h0A0 + i] = 8'h70 + 8'(i);
      launch(2'b01, 16'h00A0, 16'h0280, 16'd6, 8'h00);
      @(negedge clk);
      op = 2'b11; src_in = 16'h0199; dst_in = 16'h0050; cnt_in = 16'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk("R9", "first op src kept", src_out, 16'h00A6);
      chk("R9", "first op dst kept", dst_out, 16'h0286);
      chk("R9", "copy mode kept", flag_n, 0);
      chk("R9", "last byte copied", mem[10'h285], 8'h75);
   endtask

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_single_copy();
      t_repeat_copy_wait();
      t_search_match();
      t_search_nomatch();
      t_search_last_match();
      t_single_search();
      t_wrap_copy();
      t_start_busy();
      t_zero_count();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      bad++;
      total++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule